// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block models how a parallel NOR flash device reports progress while an internal program or erase operation runs. A command decoder outside the block turns host bus cycles into single-cycle strobes: program (with address and data), sector erase, chip erase, set-configuration and status-exit. An internal timing engine, also outside, signals when an operation completes or gives up. A small stub array holds the stored words, so the effect of each operation can be observed through reads.

While the device is in read mode, the data bus shows the stored word at the requested address. Once an operation is under way, the bus shows a status word instead, whatever the address. Bit 7 is a polling bit, bit 6 toggles on each read access and bit 5 flags an error. A two-bit configuration register chooses how bit 7 behaves while busy. It also chooses whether the device drops back to read mode by itself after a successful operation or waits for an explicit exit strobe. A failed operation always waits for that exit strobe.

Top module: `flash_status_unit`

## Requirements
- R1: The configuration register reads as 00 at power-up. A set-configuration strobe in read mode loads `cfg_val_i` only when it is 00 or 01; other values are dropped. The reset input leaves the register unchanged.
- R2: With configuration 00, while a program is busy, status bit 7 is the inverse of bit 7 of the data being programmed.
- R3: While a sector or chip erase is busy, status bit 7 is 0 under either configuration.
- R4: With configuration 01, status bit 7 is 0 while busy and 1 after the operation has finished.
- R5: Status bit 6 clears when an operation starts and inverts on each rising edge of `rd_i` while busy, so the first busy read returns 1. After the operation leaves the busy state, it holds its value.
- R6: A fail strobe while busy (pulse limit exceeded) enters the failed status state with bit 5 set, and the array is left unchanged.
- R7: A program whose data would turn a stored 0 into a 1 fails when it completes: bit 5 is set and the stored word keeps its old value.
- R8: A program or sector erase aimed at a protected sector (bit n of `prot_i` protects the sector equal to address bits [5:4]) enters the failed state at once, with bit 5 set and bit 6 at 0, and changes nothing. A chip erase clears only the unprotected sectors.
- R9: After a successful operation, configuration 00 returns to read mode at once and shows the new array contents. Configuration 01 keeps showing status until an exit strobe arrives.
- R10: After a failure, status is held under either configuration until an exit strobe. In the failed state, bit 7 is 1 under configuration 01. Under configuration 00 it is the busy polling value of the failed operation.
- R11: In every status state, bits 4 to 0 read 0. In read mode the bus shows the stored word at `addr_i`, and all words start erased (all ones).
- R12: While busy, all command strobes other than done and fail are ignored. In the hold and failed states, only the exit strobe has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (state machine and toggle bit only) |
| rd_i | input | 1 | Host read strobe, level; a rising edge is one read access |
| addr_i | input | 6 | Word address for reads and commands |
| rdata_o | output | 8 | Array word in read mode, status word otherwise |
| prog_i | input | 1 | Start program of `prog_data_i` at `addr_i` |
| prog_data_i | input | 8 | Program data |
| sect_erase_i | input | 1 | Start erase of the sector holding `addr_i` |
| chip_erase_i | input | 1 | Start erase of all unprotected sectors |
| op_done_i | input | 1 | Internal operation finished its pulses |
| op_fail_i | input | 1 | Internal operation exceeded its pulse limit |
| set_cfg_i | input | 1 | Set-configuration command |
| cfg_val_i | input | 2 | Configuration value to load |
| id_exit_i | input | 1 | Exit command, returns to read mode |
| prot_i | input | 4 | Per-sector protection mask |

## Verification
The bench targets the polling bit's dependence on configuration and operation type. A design that ignored the configuration would show the data complement where a 0 is due, or would leave hold mode without the exit strobe. It counts toggle-bit reads from a cleared start, which catches a toggle flop that is not cleared or keeps running after completion. It also drives the failure routes: a protected-sector target, a 0-to-1 program, a pulse-limit strobe and strobes issued while busy. A design that wrote the array on failure, left the failed state early, or accepted a command mid-operation would read back wrong words. Configuration values 11 and a reset pulse are sent to show that the register keeps its value.

// File: rtl/fsu_pkg.sv
`timescale 1ns/1ps
package fsu_pkg;
  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_FAIL  = 3'd4
  } fsu_state_e;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } fsu_op_e;

  localparam logic [1:0] CFG_AUTO = 2'b00;
  localparam logic [1:0] CFG_HOLD = 2'b01;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ERR_BIT  = 5;
endpackage

// File: rtl/fsu_cfg_reg.sv
`timescale 1ns/1ps
module fsu_cfg_reg
  import fsu_pkg::*;
(
  input  logic       clk_i,
  input  logic       wr_i,
  input  logic [1:0] val_i,
  output logic [1:0] cfg_o
);
  // nonvolatile-style: power-up value only, reset does not touch it
  logic [1:0] cfg_q = CFG_AUTO;
  logic       legal;

  assign legal = (val_i == CFG_AUTO) || (val_i == CFG_HOLD);

  always_ff @(posedge clk_i) begin
    if (wr_i && legal) cfg_q <= val_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/fsu_array_stub.sv
`timescale 1ns/1ps
module fsu_array_stub #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] op_addr_i,
  output logic [DATA_W-1:0] op_data_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ers_en_i,
  input  logic              ers_chip_i,
  input  logic [NSECT-1:0]  prot_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFS_W = ADDR_W - SECT_W;

  logic [DATA_W-1:0] mem_q [DEPTH] = '{default: '1};
  logic [NSECT-1:0]  sect_clr;
  logic [SECT_W-1:0] op_sect;

  assign op_sect = op_addr_i[ADDR_W-1 -: SECT_W];

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign sect_clr[s] = ers_en_i && !prot_i[s] &&
                         (ers_chip_i || op_sect == SECT_W'(s));
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (sect_clr[i >> OFS_W]) begin
        mem_q[i] <= '1;
      end else if (wr_en_i && op_addr_i == ADDR_W'(i)) begin
        mem_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign op_data_o = mem_q[op_addr_i];
endmodule

// File: rtl/fsu_op_ctrl.sv
`timescale 1ns/1ps
module fsu_op_ctrl
  import fsu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prog_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              sect_erase_i,
  input  logic              chip_erase_i,
  input  logic              op_done_i,
  input  logic              op_fail_i,
  input  logic              id_exit_i,
  input  logic [NSECT-1:0]  prot_i,
  input  logic [1:0]        cfg_i,
  input  logic [DATA_W-1:0] cur_word_i,
  output fsu_state_e        state_o,
  output fsu_op_e           op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              start_o,
  output logic              wr_en_o,
  output logic              ers_en_o,
  output logic              ers_chip_o
);
  fsu_state_e        state_q, state_d;
  fsu_op_e           op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              prot_hit;
  logic              raise_bit;

  assign prot_hit  = prot_i[addr_i[ADDR_W-1 -: SECT_W]];
  // a program may only clear bits
  assign raise_bit = |(data_q & ~cur_word_i);

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    addr_d   = addr_q;
    data_d   = data_q;
    wr_en_o  = 1'b0;
    ers_en_o = 1'b0;
    unique case (state_q)
      ST_READ: begin
        if (prog_i) begin
          op_d    = OP_PROG;
          addr_d  = addr_i;
          data_d  = prog_data_i;
          state_d = prot_hit ? ST_FAIL : ST_PROG;
        end else if (sect_erase_i) begin
          op_d    = OP_SECT;
          addr_d  = addr_i;
          state_d = prot_hit ? ST_FAIL : ST_ERASE;
        end else if (chip_erase_i) begin
          op_d    = OP_CHIP;
          state_d = ST_ERASE;
        end
      end
      ST_PROG, ST_ERASE: begin
        if (op_fail_i) begin
          state_d = ST_FAIL;
        end else if (op_done_i) begin
          if (state_q == ST_PROG && raise_bit) begin
            state_d = ST_FAIL;
          end else begin
            wr_en_o  = (state_q == ST_PROG);
            ers_en_o = (state_q == ST_ERASE);
            state_d  = (cfg_i == CFG_HOLD) ? ST_HOLD : ST_READ;
          end
        end
      end
      ST_HOLD, ST_FAIL: begin
        if (id_exit_i) state_d = ST_READ;
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign start_o    = (state_q == ST_READ) && (state_d != ST_READ);
  assign ers_chip_o = (op_q == OP_CHIP);
  assign state_o    = state_q;
  assign op_o       = op_q;
  assign op_addr_o  = addr_q;
  assign op_data_o  = data_q;
endmodule

// File: rtl/fsu_status_word.sv
`timescale 1ns/1ps
module fsu_status_word
  import fsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              start_i,
  input  fsu_state_e        state_i,
  input  fsu_op_e           op_i,
  input  logic [1:0]        cfg_i,
  input  logic              data_msb_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic              toggle_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic rd_q;
  logic tog_q;
  logic busy;
  logic rd_rise;
  logic poll;
  logic busy_poll;
  logic hold_cfg;

  assign busy    = (state_i == ST_PROG) || (state_i == ST_ERASE);
  assign rd_rise = rd_i && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (start_i) begin
        tog_q <= 1'b0;
      end else if (busy && rd_rise) begin
        tog_q <= !tog_q;
      end
    end
  end

  assign hold_cfg  = (cfg_i == CFG_HOLD);
  // polling value while an operation is still outstanding
  assign busy_poll = hold_cfg ? 1'b0 : ((op_i == OP_PROG) ? !data_msb_i : 1'b0);

  always_comb begin
    unique case (state_i)
      ST_PROG, ST_ERASE: poll = busy_poll;
      ST_HOLD:           poll = 1'b1;
      ST_FAIL:           poll = hold_cfg ? 1'b1 : busy_poll;
      default:           poll = 1'b0;
    endcase
  end

  always_comb begin
    if (state_i == ST_READ) begin
      rdata_o = arr_data_i;
    end else begin
      rdata_o           = '0;
      rdata_o[POLL_BIT] = poll;
      rdata_o[TOG_BIT]  = tog_q;
      rdata_o[ERR_BIT]  = (state_i == ST_FAIL);
    end
  end

  assign toggle_o = tog_q;
endmodule

// File: rtl/flash_status_unit.sv
`timescale 1ns/1ps
module flash_status_unit
  import fsu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic [5:0] addr_i,
  output logic [7:0] rdata_o,
  input  logic       prog_i,
  input  logic [7:0] prog_data_i,
  input  logic       sect_erase_i,
  input  logic       chip_erase_i,
  input  logic       op_done_i,
  input  logic       op_fail_i,
  input  logic       set_cfg_i,
  input  logic [1:0] cfg_val_i,
  input  logic       id_exit_i,
  input  logic [3:0] prot_i
);
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int SECT_W = 2;

  fsu_state_e        state_q;
  fsu_op_e           op_q;
  logic [1:0]        cfg_q;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] arr_rd;
  logic [DATA_W-1:0] arr_op;
  logic              start;
  logic              wr_en;
  logic              ers_en;
  logic              ers_chip;
  logic              toggle_q;

  fsu_cfg_reg u_cfg (
    .clk_i (clk_i),
    .wr_i  (set_cfg_i && state_q == ST_READ),
    .val_i (cfg_val_i),
    .cfg_o (cfg_q)
  );

  fsu_op_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .prog_i       (prog_i),
    .prog_data_i  (prog_data_i),
    .sect_erase_i (sect_erase_i),
    .chip_erase_i (chip_erase_i),
    .op_done_i    (op_done_i),
    .op_fail_i    (op_fail_i),
    .id_exit_i    (id_exit_i),
    .prot_i       (prot_i),
    .cfg_i        (cfg_q),
    .cur_word_i   (arr_op),
    .state_o      (state_q),
    .op_o         (op_q),
    .op_addr_o    (op_addr),
    .op_data_o    (op_data),
    .start_o      (start),
    .wr_en_o      (wr_en),
    .ers_en_o     (ers_en),
    .ers_chip_o   (ers_chip)
  );

  fsu_array_stub #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk_i      (clk_i),
    .rd_addr_i  (addr_i),
    .rd_data_o  (arr_rd),
    .op_addr_i  (op_addr),
    .op_data_o  (arr_op),
    .wr_en_i    (wr_en),
    .wr_data_i  (op_data),
    .ers_en_i   (ers_en),
    .ers_chip_i (ers_chip),
    .prot_i     (prot_i)
  );

  fsu_status_word #(.DATA_W(DATA_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .start_i    (start),
    .state_i    (state_q),
    .op_i       (op_q),
    .cfg_i      (cfg_q),
    .data_msb_i (op_data[DATA_W-1]),
    .arr_data_i (arr_rd),
    .toggle_o   (toggle_q),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/fsu_checker.sv
`timescale 1ns/1ps
module fsu_checker
  import fsu_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rdata_o,
  input logic       set_cfg_i,
  input logic       op_done_i,
  input logic       op_fail_i,
  input logic       id_exit_i,
  input fsu_state_e state_q,
  input logic [1:0] cfg_q,
  input logic       toggle_q
);
  assert_cfg_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[1] == 1'b0);

  assert_cfg_write_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(set_cfg_i) && $past(state_q == ST_READ));

  assert_erase_poll_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ERASE |-> !rdata_o[7]);

  assert_hold_cfg_busy_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG || state_q == ST_ERASE) && cfg_q == CFG_HOLD |-> !rdata_o[7]);

  assert_toggle_rise_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(toggle_q) |-> $past(state_q == ST_PROG || state_q == ST_ERASE));

  assert_fail_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FAIL |-> rdata_o[5]);

  assert_hold_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOLD && !id_exit_i |=> state_q == ST_HOLD);

  assert_fail_stays_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FAIL && !id_exit_i |=> state_q == ST_FAIL);

  assert_low_bits_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_READ |-> rdata_o[4:0] == 5'd0);

  assert_busy_ignores_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PROG && !op_done_i && !op_fail_i |=> state_q == ST_PROG);
endmodule

bind flash_status_unit fsu_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rdata_o   (rdata_o),
  .set_cfg_i (set_cfg_i),
  .op_done_i (op_done_i),
  .op_fail_i (op_fail_i),
  .id_exit_i (id_exit_i),
  .state_q   (state_q),
  .cfg_q     (cfg_q),
  .toggle_q  (toggle_q)
);

// File: tb/tb_flash_status_unit.sv
`timescale 1ns/1ps
module tb_flash_status_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] rdata_o;
  logic       prog_i = 1'b0;
  logic [7:0] prog_data_i = '0;
  logic       sect_erase_i = 1'b0;
  logic       chip_erase_i = 1'b0;
  logic       op_done_i = 1'b0;
  logic       op_fail_i = 1'b0;
  logic       set_cfg_i = 1'b0;
  logic [1:0] cfg_val_i = '0;
  logic       id_exit_i = 1'b0;
  logic [3:0] prot_i = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = !clk_i;

  flash_status_unit dut (.*);

  // {cfg, kind, addr, data, exp_busy, exp_post, exp_after_exit}
  // kind 0 = program+done, 1 = program+fail, 2 = sector erase+done
  localparam int NVEC = 8;
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 6'h05, 8'h3C, 8'hC0, 8'h3C, 8'h3C},
    {1'b0, 2'd0, 6'h16, 8'hA5, 8'h40, 8'hA5, 8'hA5},
    {1'b1, 2'd0, 6'h07, 8'h0F, 8'h40, 8'hC0, 8'h0F},
    {1'b1, 2'd1, 6'h08, 8'h00, 8'h40, 8'hE0, 8'hFF},
    {1'b0, 2'd1, 6'h09, 8'h92, 8'h40, 8'h60, 8'hFF},
    {1'b0, 2'd0, 6'h05, 8'hFF, 8'h40, 8'h60, 8'h3C},
    {1'b0, 2'd2, 6'h16, 8'h00, 8'h40, 8'hFF, 8'hFF},
    {1'b0, 2'd0, 6'h31, 8'h00, 8'hA0, 8'hA0, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    rd_i = 1'b1;
    @(negedge clk_i);
    d = rdata_o;
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic set_cfg(input logic [1:0] v);
    @(negedge clk_i);
    set_cfg_i = 1'b1; cfg_val_i = v;
    @(negedge clk_i);
    set_cfg_i = 1'b0;
  endtask

  task automatic prog(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i);
    prog_i = 1'b1; addr_i = a; prog_data_i = d;
    @(negedge clk_i);
    prog_i = 1'b0;
  endtask

  task automatic sect_erase(input logic [5:0] a);
    @(negedge clk_i);
    sect_erase_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    sect_erase_i = 1'b0;
  endtask

  task automatic chip_erase();
    @(negedge clk_i);
    chip_erase_i = 1'b1;
    @(negedge clk_i);
    chip_erase_i = 1'b0;
  endtask

  task automatic done();
    @(negedge clk_i); op_done_i = 1'b1;
    @(negedge clk_i); op_done_i = 1'b0;
  endtask

  task automatic fail();
    @(negedge clk_i); op_fail_i = 1'b1;
    @(negedge clk_i); op_fail_i = 1'b0;
  endtask

  task automatic exit_cmd();
    @(negedge clk_i); id_exit_i = 1'b1;
    @(negedge clk_i); id_exit_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [40:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset / power-up state
    rd(6'h00, d); chk("R11 erased word after reset", d, 8'hFF);
    prog(6'h20, 8'h00);
    rd(6'h20, d); chk("R1 power-up cfg 00 poll", d, 8'hC0);
    done();
    rd(6'h20, d); chk("R9 auto return shows data", d, 8'h00);

    // vector table
    prot_i = 4'b1000;
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      set_cfg({1'b0, v[40]});
      if (v[39:38] == 2'd2) sect_erase(v[37:32]);
      else prog(v[37:32], v[31:24]);
      rd(v[37:32], d); chk($sformatf("R2/R3/R8 vec%0d busy", i), d, v[23:16]);
      if (v[39:38] == 2'd1) fail();
      else done();
      rd(v[37:32], d); chk($sformatf("R4/R6/R7/R9/R10 vec%0d post", i), d, v[15:8]);
      exit_cmd();
      rd(v[37:32], d); chk($sformatf("R6/R7/R8/R10 vec%0d array", i), d, v[7:0]);
    end

    // R1: illegal value dropped, reset keeps cfg 01
    set_cfg(2'b01);
    set_cfg(2'b11);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    prog(6'h22, 8'h00);
    rd(6'h22, d); chk("R1 cfg 01 survives reset and 11", d, 8'h40);
    done();
    rd(6'h22, d); chk("R4 hold poll high", d, 8'hC0);
    rd(6'h22, d); chk("R9 hold persists", d, 8'hC0);
    exit_cmd();
    rd(6'h22, d); chk("R9 exit shows data", d, 8'h00);

    // R5: toggle sequence
    set_cfg(2'b00);
    prog(6'h21, 8'hFF);
    rd(6'h21, d); chk("R5 toggle read 1", d, 8'h40);
    rd(6'h21, d); chk("R5 toggle read 2", d, 8'h00);
    rd(6'h21, d); chk("R5 toggle read 3", d, 8'h40);
    done();
    rd(6'h21, d); chk("R5 done returns data", d, 8'hFF);

    // R12: commands during busy ignored
    prog(6'h23, 8'h55);
    rd(6'h23, d); chk("R12 busy poll", d, 8'hC0);
    set_cfg(2'b01);
    prog(6'h24, 8'h00);
    exit_cmd();
    rd(6'h23, d); chk("R12 still busy after strobes", d, 8'h80);
    done();
    rd(6'h23, d); chk("R12 cfg unchanged, auto return", d, 8'h55);
    rd(6'h24, d); chk("R12 second program dropped", d, 8'hFF);

    // R8: chip erase skips protected sector 0
    prot_i = 4'b0001;
    chip_erase();
    rd(6'h00, d); chk("R3 chip erase poll", d, 8'h40);
    done();
    rd(6'h07, d); chk("R8 protected word kept", d, 8'h0F);
    rd(6'h20, d); chk("R8 unprotected word erased", d, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule